// File: doc/BRIEF.md
# Filtered-Pattern Scan BIST Sequencer

This block drives the scan path of a core under self-test from a pseudorandom source, but shifts only those patterns that were found useful beforehand. A linear feedback shift register advances one step on every shift slot of every pattern index, whether or not that pattern is applied. The scan shift enable, and with it the gated scan clock, is raised only for indices that fall inside one of a few programmed inclusive index windows. Patterns outside every window never reach the scan chain. The generator still advances for them, so the patterns that do get applied are the same ones an unfiltered run would have produced at those indices.

After each applied pattern has been fully shifted, one capture pulse is issued. The response word from the core is folded into a multiple-input signature register in that same cycle. Once the programmed number of pattern indices has been covered, the block reports completion. It also reports whether the final signature equals an expected value. The choice of windows is made offline and supplied as static inputs. The window, count and expected-signature inputs are held stable while a run is in progress.

Top module: `vf_bist_gate`

## Requirements
- R1: After reset, shift_en_o, scan_in_o, capture_o, done_o and pass_o are 0 and signature_o is 0.
- R2: The generator is a 16-bit register loaded with seed 0xACE1 when a run starts. Each step shifts it right and puts bit0^bit2^bit3^bit5 of the old value into bit 15. It steps exactly once per shift slot: SCAN_LEN (8) slots for every pattern index, applied or not. It holds during capture cycles.
- R3: Pattern index p is applied when, for some window k of 4, range_en_i[k] is 1 and lo_k <= p <= hi_k. Window k occupies bits [8k+7:8k] of range_lo_i and of range_hi_i. A window with lo > hi selects nothing.
- R4: During an applied pattern, shift_en_o is 1 for exactly 8 consecutive cycles, and scan_in_o carries generator bit 0 in each of them. During a skipped pattern, the block spends 8 cycles with shift_en_o at 0. Whenever shift_en_o is 0, scan_in_o is 0.
- R5: capture_o is 1 for exactly one cycle, directly after the last shift cycle of an applied pattern, and at no other time.
- R6: The signature is cleared to 0 when a run starts. It changes only in a capture cycle, to (sig<<1) ^ (sig[15] ? 0x1021 : 0) ^ resp_i (zero-extended).
- R7: done_o rises after all total_i pattern indices (0 to total_i-1) have been covered. With total_i = 0 it rises in the cycle after start. It then stays at 1, with the signature unchanged, until the next start.
- R8: pass_o is 1 exactly when done_o is 1 and signature_o equals exp_sig_i.
- R9: start_i is ignored while a run is in progress. It is honoured only when the block is idle or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (idle or done only) |
| range_en_i | input | 4 | Per-window enable |
| range_lo_i | input | 32 | Window lower bounds, 8 bits each |
| range_hi_i | input | 32 | Window upper bounds, 8 bits each |
| total_i | input | 8 | Number of pattern indices in the run |
| resp_i | input | 4 | Core response folded in on capture |
| exp_sig_i | input | 16 | Expected final signature |
| scan_in_o | output | 1 | Serial scan data to the chain |
| shift_en_o | output | 1 | Scan shift enable / clock gate |
| capture_o | output | 1 | One-cycle capture pulse |
| done_o | output | 1 | Run complete |
| pass_o | output | 1 | Signature matches expected while done |
| signature_o | output | 16 | Current signature |

## Verification
Directed runs exercise specific window settings:
- An empty run, which shows done comes up with no patterns.
- Windows that are disabled or inverted, which separate window enable and ordering from plain range logic.
- Single-index windows placed on their own bounds, which show that both limits are inclusive.
- One window covering everything, which shows capture spacing under back-to-back applied patterns.
- Overlapping windows, which show that a pattern selected by two windows is still applied only once.

Seeded random windows and counts then compare the per-cycle scan stream against a bench generator. A stream that drifts after a skipped pattern shows that the generator stopped advancing during filtering. A start pulse in the middle of a run, and response noise outside capture cycles, must leave the stream and the signature unchanged.

// File: rtl/vf_pkg.sv
package vf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } vf_state_e;
endpackage

// File: rtl/vf_lfsr.sv
module vf_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'h002D
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic fb;
  assign fb = ^(state_o & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_o <= SEED;
    else if (load_i)  state_o <= SEED;
    else if (step_i)  state_o <= {fb, state_o[W-1:1]};
  end
endmodule

// File: rtl/vf_range_match.sv
module vf_range_match #(
  parameter int N     = 4,
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [N-1:0]       en_i,
  input  logic [N*IDX_W-1:0] lo_i,
  input  logic [N*IDX_W-1:0] hi_i,
  output logic               hit_o
);
  logic [N-1:0] win_hit;

  for (genvar k = 0; k < N; k++) begin : g_win
    logic [IDX_W-1:0] lo, hi;
    assign lo = lo_i[k*IDX_W +: IDX_W];
    assign hi = hi_i[k*IDX_W +: IDX_W];
    assign win_hit[k] = en_i[k] && (idx_i >= lo) && (idx_i <= hi);
  end

  assign hit_o = |win_hit;
endmodule

// File: rtl/vf_misr.sv
module vf_misr #(
  parameter int           W     = 16,
  parameter int           IN_W  = 4,
  parameter logic [W-1:0] POLY  = 16'h1021
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [IN_W-1:0] data_i,
  output logic [W-1:0]    sig_o
);
  logic [W-1:0] nxt;
  assign nxt = {sig_o[W-2:0], 1'b0} ^ (sig_o[W-1] ? POLY : '0)
             ^ {{(W-IN_W){1'b0}}, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sig_o <= '0;
    else if (clr_i) sig_o <= '0;
    else if (en_i)  sig_o <= nxt;
  end
endmodule

// File: rtl/vf_bist_gate.sv
module vf_bist_gate #(
  parameter int                N_RANGES = 4,
  parameter int                IDX_W    = 8,
  parameter int                SCAN_LEN = 8,
  parameter int                LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] SEED     = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS     = 16'h002D,
  parameter int                MISR_W   = 16,
  parameter logic [MISR_W-1:0] POLY     = 16'h1021,
  parameter int                RSP_W    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [N_RANGES-1:0]       range_en_i,
  input  logic [N_RANGES*IDX_W-1:0] range_lo_i,
  input  logic [N_RANGES*IDX_W-1:0] range_hi_i,
  input  logic [IDX_W-1:0]          total_i,
  input  logic [RSP_W-1:0]          resp_i,
  input  logic [MISR_W-1:0]         exp_sig_i,
  output logic                      scan_in_o,
  output logic                      shift_en_o,
  output logic                      capture_o,
  output logic                      done_o,
  output logic                      pass_o,
  output logic [MISR_W-1:0]         signature_o
);
  import vf_pkg::*;

  localparam int CNT_W = (SCAN_LEN > 1) ? $clog2(SCAN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SCAN_LEN - 1);

  vf_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit, start_ok, last_idx;
  logic [LFSR_W-1:0] lfsr;

  assign start_ok = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign last_idx = (idx_q == total_i - IDX_W'(1));

  vf_range_match #(.N(N_RANGES), .IDX_W(IDX_W)) u_match (
    .idx_i (idx_q),
    .en_i  (range_en_i),
    .lo_i  (range_lo_i),
    .hi_i  (range_hi_i),
    .hit_o (hit)
  );

  vf_lfsr #(.W(LFSR_W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_ok),
    .step_i  (state_q == ST_SHIFT),
    .state_o (lfsr)
  );

  vf_misr #(.W(MISR_W), .IN_W(RSP_W), .POLY(POLY)) u_misr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .en_i   (state_q == ST_CAPT),
    .data_i (resp_i),
    .sig_o  (signature_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (start_ok) begin
      idx_q   <= '0;
      cnt_q   <= '0;
      state_q <= (total_i == '0) ? ST_DONE : ST_SHIFT;
    end else begin
      unique case (state_q)
        ST_SHIFT: begin
          if (cnt_q == LAST_BIT) begin
            cnt_q <= '0;
            if (hit)           state_q <= ST_CAPT;
            else if (last_idx) state_q <= ST_DONE;
            else               idx_q   <= idx_q + IDX_W'(1);
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_CAPT: begin
          if (last_idx) state_q <= ST_DONE;
          else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_SHIFT;
          end
        end
        default: ;
      endcase
    end
  end

  // clock gate follows the filter; data held quiet when gated
  assign shift_en_o = (state_q == ST_SHIFT) && hit;
  assign scan_in_o  = shift_en_o & lfsr[0];
  assign capture_o  = (state_q == ST_CAPT);
  assign done_o     = (state_q == ST_DONE);
  assign pass_o     = done_o && (signature_o == exp_sig_i);
endmodule

module vf_bist_gate_chk #(
  parameter int MISR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              scan_in_o,
  input logic              shift_en_o,
  input logic              capture_o,
  input logic              done_o,
  input logic              pass_o,
  input logic [MISR_W-1:0] signature_o
);
  // R4
  scan_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_o |-> !scan_in_o);
  // R5
  capture_after_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> $past(shift_en_o));
  // R5
  capture_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> !capture_o);
  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(signature_o)));
  // R8
  pass_only_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o);
  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!shift_en_o && !capture_o));
endmodule

bind vf_bist_gate vf_bist_gate_chk #(.MISR_W(MISR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .scan_in_o   (scan_in_o),
  .shift_en_o  (shift_en_o),
  .capture_o   (capture_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .signature_o (signature_o)
);

// File: tb/vf_bist_gate_bench.sv
module vf_bist_gate_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  range_en_i = '0;
  logic [31:0] range_lo_i = '0;
  logic [31:0] range_hi_i = '0;
  logic [7:0]  total_i = '0;
  logic [3:0]  resp_i = '0;
  logic [15:0] exp_sig_i = '0;
  logic        scan_in_o, shift_en_o, capture_o, done_o, pass_o;
  logic [15:0] signature_o;

  int errors = 0;
  int checks = 0;
  int unsigned seed_v;

  logic [7:0] lo [4];
  logic [7:0] hi [4];
  logic       en [4];

  always #4 clk_i = ~clk_i;

  vf_bist_gate u_vf_bist_gate (.*);

  function automatic logic [15:0] lfsr_step(logic [15:0] l);
    return {l[0] ^ l[2] ^ l[3] ^ l[5], l[15:1]};
  endfunction

  function automatic logic [15:0] misr_step(logic [15:0] m, logic [3:0] r);
    return {m[14:0], 1'b0} ^ (m[15] ? 16'h1021 : 16'h0) ^ {12'h0, r};
  endfunction

  function automatic bit is_ess(int p);
    for (int k = 0; k < 4; k++)
      if (en[k] && p >= lo[k] && p <= hi[k]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply_ranges();
    for (int k = 0; k < 4; k++) begin
      range_en_i[k] = en[k];
      range_lo_i[k*8 +: 8] = lo[k];
      range_hi_i[k*8 +: 8] = hi[k];
    end
  endtask

  task automatic run(int tot, bit mid_start);
    logic [15:0] l, m;
    logic [3:0]  r;
    int s_bad, c_bad, d_bad, s_act, s_exp, caps;
    bit e;
    apply_ranges();
    total_i = 8'(tot);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    l = 16'hACE1; m = '0; s_bad = 0; c_bad = 0; d_bad = 0; caps = 0;
    s_act = 0; s_exp = 0;
    for (int p = 0; p < tot; p++) begin
      e = is_ess(p);
      for (int b = 0; b < 8; b++) begin
        if (shift_en_o !== e || scan_in_o !== (e & l[0])) begin
          if (s_bad == 0) begin
            s_act = {shift_en_o, scan_in_o};
            s_exp = {e, e & l[0]};
          end
          s_bad++;
        end
        if (capture_o !== 1'b0) c_bad++;
        if (done_o !== 1'b0) d_bad++;
        l = lfsr_step(l);
        resp_i = 4'($urandom);   // noise outside capture
        start_i = (mid_start && p == 1 && b == 3);
        @(negedge clk_i);
      end
      if (e) begin
        if (capture_o !== 1'b1 || shift_en_o !== 1'b0) c_bad++;
        caps++;
        r = 4'($urandom);
        resp_i = r;
        start_i = 1'b0;
        m = misr_step(m, r);
        @(negedge clk_i);
      end
    end
    start_i = 1'b0;
    // R2 R4 R9: per-cycle scan stream
    check(s_bad == 0, "R4", "scan stream", s_act, s_exp);
    // R5
    check(c_bad == 0, "R5", "capture timing", c_bad, 0);
    // R7
    check(d_bad == 0 && done_o === 1'b1, "R7", "done", done_o, 1);
    // R6
    check(signature_o === m, "R6", "signature", signature_o, m);
    exp_sig_i = m;
    #1 check(pass_o === 1'b1, "R8", "pass on match", pass_o, 1);
    exp_sig_i = m ^ 16'h0040;
    #1 check(pass_o === 1'b0, "R8", "pass on mismatch", pass_o, 0);
    resp_i = 4'hF;
    repeat (3) @(negedge clk_i);
    check(done_o === 1'b1 && signature_o === m, "R7", "done hold", signature_o, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    seed_v = 32'd587;
    void'($urandom(seed_v));
    for (int k = 0; k < 4; k++) begin lo[k] = 0; hi[k] = 0; en[k] = 0; end
    #3;
    // R1
    check(shift_en_o === 0 && capture_o === 0 && done_o === 0 && scan_in_o === 0
          && pass_o === 0 && signature_o === 0, "R1", "reset outputs", signature_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R7: empty run
    run(0, 0);
    // R3: disabled windows and inverted window select nothing
    lo[0] = 2; hi[0] = 9; en[0] = 0;
    lo[1] = 7; hi[1] = 3; en[1] = 1;
    run(12, 0);
    // R3: inclusive single-index windows on bounds
    lo[0] = 0; hi[0] = 0; en[0] = 1;
    lo[1] = 5; hi[1] = 5; en[1] = 1;
    lo[2] = 9; hi[2] = 9; en[2] = 1;
    run(10, 0);
    // R5: all patterns applied back to back
    for (int k = 0; k < 4; k++) en[k] = 0;
    lo[3] = 0; hi[3] = 255; en[3] = 1;
    run(6, 0);
    // R3: overlapping windows, R9: start mid-run ignored
    lo[0] = 2; hi[0] = 6; en[0] = 1;
    lo[1] = 4; hi[1] = 8; en[1] = 1;
    en[3] = 0;
    run(11, 1);
    // random windows and counts
    for (int t = 0; t < 6; t++) begin
      for (int k = 0; k < 4; k++) begin
        lo[k] = 8'($urandom_range(0, 30));
        hi[k] = lo[k] + 8'($urandom_range(0, 6));
        en[k] = 1'($urandom);
      end
      run($urandom_range(1, 32), t[0]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule